// File: doc/BRIEF.md
# Programmable DRAM Command Sequencer

This block replays a short list of DRAM commands that software programs into registers. It is meant for memory training and test traffic. The list has up to four slots. Each slot holds one command with a rank select, a repeat count, a gap between repeats and a wait after its last repeat. It also holds a data-direction tag, a starting bank and address, and rules for stepping the bank and address on each repeat. Writing the run-control register starts the engine. It walks the active slots in order, replays the whole list the programmed number of times, and then sets a completion bit in the status register.

The block has no data path of its own. Each cycle that carries a command shows `cmd_valid` together with the command code, a one-hot chip select, the bank and address, and the direction tag. A PHY downstream uses the tag to open a read or write data window, and this holds for NOP slots too. A timer mode runs the same schedule with no commands emitted, so a run can serve as a programmable delay.

The controller is built around a four-state machine:
- IDLE → ISSUE on a start.
- ISSUE → ISSUE when another repeat follows with a gap of 0, or when the next slot follows with a wait of 0.
- ISSUE → GAP when another repeat follows and the gap is not 0.
- GAP → ISSUE when the gap count runs out.
- ISSUE → WAIT after the last repeat when the wait is not 0.
- WAIT → ISSUE for the next slot or the next loop.
- WAIT or ISSUE → IDLE after the final wait of the final loop.

Top module: `dcs_cmd_seq`

## Requirements
- R1: After reset `busy` is 0, `cmd_valid` is 0, and the status register (word 17) and the run-control register (word 16) read 0.
- R2: A write to word 16 while idle starts a run. `busy` is 1 from the next cycle. Both done bits clear. The first command of slot 0 appears in the cycle right after the clock edge that takes the write.
- R3: The repeat count is in timing-word bits [9:0] (timing word = word 4*s+1). A slot emits its command exactly that many times, and a count of 0 acts as 1.
- R4: The gap is in timing-word bits [17:10]. Two consecutive repeats of one slot are gap+1 cycles apart, so a gap of 0 gives back-to-back commands.
- R5: The trailing wait is in timing-word bits [25:18]. The first command of the next slot, or of the next loop, comes wait+1 cycles after the last repeat of the current slot.
- R6: Slots run in order from 0 to the slot count. The slot count is run-control bits [19:18] and equals the number of active slots minus one. The list is replayed as many times as run-control bits [7:0] say, and a value of 0 acts as 1.
- R7: The start address is in word 4*s+2, bits [17:0], and the start bank is in bits [20:18]. The update word is 4*s+3. Bit 0 steps the bank by 1 modulo 8 after each repeat that is not the last. Bit 1 does the same for the address. Bits [6:2] give a wrap position w: for w from 1 to 17 the address is kept modulo 2^w, and any other w wraps at 18 bits. Every entry into a slot restarts from the programmed start values, so a repeat count of 1 never steps.
- R8: The direction tag is in timing-word bits [27:26], with 0 for none, 1 for read and 2 for write. It is output on `cmd_dir` with every command the slot emits, NOP commands included.
- R9: The command word is 4*s. `cmd_code` carries bits [2:0], coded 0 NOP, 1 ACT, 2 PRE, 3 MRS, 4 ZQCS, 5 RD, 6 WR, 7 alternate NOP. `cmd_cs` is the one-hot decode of rank bits [5:4]. All command outputs are 0 when `cmd_valid` is 0.
- R10: In the cycle after the final wait of the final loop, `busy` is 0 and status bit 4 reads 1. Reading the status register does not clear it.
- R11: When run-control bit 22 is set, the run keeps the same schedule but emits no command. It ends with status bit 6 set and bit 4 clear.
- R12: While busy, writes to slot words and to the run-control word have no effect. They neither change the register contents nor start a new run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word index (0-15 slots, 16 run control, 17 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| cmd_valid | output | 1 | A command is presented this cycle |
| cmd_code | output | 3 | Command code |
| cmd_cs | output | 4 | One-hot chip select |
| cmd_bank | output | 3 | Bank address |
| cmd_addr | output | 18 | Row/column address |
| cmd_dir | output | 2 | Data-direction tag |
| busy | output | 1 | A run is in progress |

## Verification
The hardest thing to reach from the ports is a cycle in which several boundaries fall together. One case is the last repeat of the last slot of a non-final loop, where the wait runs out and the list wraps back to slot 0, the loop count advances and the address reloads. The other is an address step that crosses its wrap position in that same run. The directed stimulus reaches both with a four-slot, two-loop list that mixes zero and non-zero gaps and waits. One slot steps both bank and address from just below a 3-bit wrap. A bench model derives the exact cycle, address, bank and tag of every command from the programmed fields, and each emitted command is compared to the model in its own cycle. A separate run injects slot and run-control writes while the engine is busy.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
    localparam int NSLOT   = 4;
    localparam int SLOT_W  = $clog2(NSLOT);
    localparam int NWORD   = NSLOT * 4;
    localparam int WIDX_W  = $clog2(NWORD);
    localparam int REG_AW  = 5;
    localparam int ADDR_W  = 18;
    localparam int BANK_W  = 3;
    localparam int REP_W   = 10;
    localparam int DLY_W   = 8;
    localparam int LOOP_W  = 8;
    localparam int WRAP_W  = 5;
    localparam int RANK_W  = 2;
    localparam int CS_W    = 1 << RANK_W;

    // register word indices
    localparam int REG_CTRL = NWORD;
    localparam int REG_STAT = NWORD + 1;

    // slot field positions
    localparam int CODE_LSB = 0;
    localparam int RANK_LSB = 4;
    localparam int REP_LSB  = 0;
    localparam int GAP_LSB  = 10;
    localparam int WAIT_LSB = 18;
    localparam int DIR_LSB  = 26;
    localparam int ADR_LSB  = 0;
    localparam int BNK_LSB  = 18;
    localparam int SB_BIT   = 0;
    localparam int SA_BIT   = 1;
    localparam int WRAP_LSB = 2;

    // run control and status positions
    localparam int LAST_LSB = 18;
    localparam int TMR_BIT  = 22;
    localparam int ST_BUSY  = 0;
    localparam int ST_DONE  = 4;
    localparam int ST_TDONE = 6;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0, CMD_ACT = 3'd1, CMD_PRE = 3'd2, CMD_MRS = 3'd3,
        CMD_ZQCS = 3'd4, CMD_RD = 3'd5, CMD_WR = 3'd6, CMD_NOP2 = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0, DIR_RD = 2'd1, DIR_WR = 2'd2, DIR_RSV = 2'd3
    } dir_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0, S_ISSUE = 2'd1, S_GAP = 2'd2, S_WAIT = 2'd3
    } seq_state_e;

    typedef struct packed {
        cmd_e              code;
        logic [RANK_W-1:0] rank;
        logic [REP_W-1:0]  reps;
        logic [DLY_W-1:0]  gap;
        logic [DLY_W-1:0]  hold;
        dir_e              dir;
        logic [ADDR_W-1:0] addr;
        logic [BANK_W-1:0] bank;
        logic              step_bank;
        logic              step_addr;
        logic [WRAP_W-1:0] wrap;
    } slot_cfg_t;
endpackage

// File: rtl/dcs_regfile.sv
module dcs_regfile
    import dcs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [REG_AW-1:0]     addr,
    input  logic [31:0]           wdata,
    input  logic                  busy,
    input  logic                  run_end,
    output logic [31:0]           rdata,
    output logic                  start,
    output slot_cfg_t             cfg [NSLOT],
    output logic [LOOP_W-1:0]     loops,
    output logic [SLOT_W-1:0]     last_slot,
    output logic                  timer,
    output logic                  done_n,
    output logic                  done_t,
    output logic [NWORD*32-1:0]   slot_flat
);
    logic [31:0] words [NWORD];
    logic [31:0] ctrl;
    logic        slot_hit;

    assign slot_hit = addr < REG_AW'(NWORD);
    assign start    = we && !busy && (addr == REG_AW'(REG_CTRL));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORD; i++) words[i] <= '0;
            ctrl <= '0;
        end else if (we && !busy) begin
            if (slot_hit)
                words[addr[WIDX_W-1:0]] <= wdata;
            else if (addr == REG_AW'(REG_CTRL))
                ctrl <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_n <= 1'b0;
            done_t <= 1'b0;
        end else if (start) begin
            done_n <= 1'b0;
            done_t <= 1'b0;
        end else if (run_end) begin
            if (timer) done_t <= 1'b1;
            else       done_n <= 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        if (slot_hit) begin
            rdata = words[addr[WIDX_W-1:0]];
        end else if (addr == REG_AW'(REG_CTRL)) begin
            rdata = ctrl;
        end else if (addr == REG_AW'(REG_STAT)) begin
            rdata[ST_BUSY]  = busy;
            rdata[ST_DONE]  = done_n;
            rdata[ST_TDONE] = done_t;
        end
    end

    assign loops     = ctrl[LOOP_W-1:0];
    assign last_slot = ctrl[LAST_LSB +: SLOT_W];
    assign timer     = ctrl[TMR_BIT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign cfg[g].code      = cmd_e'(words[4*g][CODE_LSB +: 3]);
        assign cfg[g].rank      = words[4*g][RANK_LSB +: RANK_W];
        assign cfg[g].reps      = words[4*g+1][REP_LSB +: REP_W];
        assign cfg[g].gap       = words[4*g+1][GAP_LSB +: DLY_W];
        assign cfg[g].hold      = words[4*g+1][WAIT_LSB +: DLY_W];
        assign cfg[g].dir       = dir_e'(words[4*g+1][DIR_LSB +: 2]);
        assign cfg[g].addr      = words[4*g+2][ADR_LSB +: ADDR_W];
        assign cfg[g].bank      = words[4*g+2][BNK_LSB +: BANK_W];
        assign cfg[g].step_bank = words[4*g+3][SB_BIT];
        assign cfg[g].step_addr = words[4*g+3][SA_BIT];
        assign cfg[g].wrap      = words[4*g+3][WRAP_LSB +: WRAP_W];
    end

    for (genvar w = 0; w < NWORD; w++) begin : g_flat
        assign slot_flat[32*w +: 32] = words[w];
    end
endmodule

// File: rtl/dcs_fsm.sv
module dcs_fsm
    import dcs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [LOOP_W-1:0]  loops,
    input  logic [SLOT_W-1:0]  last_slot,
    input  logic [REP_W-1:0]   reps,
    input  logic [DLY_W-1:0]   gap,
    input  logic [DLY_W-1:0]   hold,
    output logic [SLOT_W-1:0]  slot,
    output logic [SLOT_W-1:0]  nxt_slot,
    output logic               load,
    output logic               step,
    output logic               issue,
    output logic               busy,
    output logic               run_end
);
    seq_state_e         state, nstate;
    logic [REP_W-1:0]   rep_cnt, nrep;
    logic [LOOP_W-1:0]  loop_cnt, nloop;
    logic [DLY_W-1:0]   dly_cnt, ndly;
    logic [SLOT_W-1:0]  nslot;
    logic [REP_W-1:0]   reps_m1;
    logic [LOOP_W-1:0]  loops_m1;
    logic               last_rep, last_loop, advance;

    assign reps_m1   = (reps == '0)  ? '0 : reps - 1'b1;
    assign loops_m1  = (loops == '0) ? '0 : loops - 1'b1;
    assign last_rep  = (rep_cnt == reps_m1);
    assign last_loop = (loop_cnt == loops_m1);

    // next-state and counter logic
    always_comb begin
        nstate  = state;
        nslot   = slot;
        nrep    = rep_cnt;
        nloop   = loop_cnt;
        ndly    = dly_cnt;
        load    = 1'b0;
        step    = 1'b0;
        run_end = 1'b0;
        advance = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    nstate = S_ISSUE;
                    nslot  = '0;
                    nrep   = '0;
                    nloop  = '0;
                    load   = 1'b1;
                end
            end
            S_ISSUE: begin
                if (!last_rep) begin
                    nrep = rep_cnt + 1'b1;
                    step = 1'b1;
                    if (gap != '0) begin
                        nstate = S_GAP;
                        ndly   = gap - 1'b1;
                    end
                end else if (hold == '0) begin
                    advance = 1'b1;
                end else begin
                    nstate = S_WAIT;
                    ndly   = hold - 1'b1;
                end
            end
            S_GAP: begin
                if (dly_cnt == '0) nstate = S_ISSUE;
                else               ndly   = dly_cnt - 1'b1;
            end
            S_WAIT: begin
                if (dly_cnt == '0) advance = 1'b1;
                else               ndly    = dly_cnt - 1'b1;
            end
        endcase
        if (advance) begin
            if (slot == last_slot) begin
                if (last_loop) begin
                    nstate  = S_IDLE;
                    run_end = 1'b1;
                end else begin
                    nstate = S_ISSUE;
                    nslot  = '0;
                    nloop  = loop_cnt + 1'b1;
                    nrep   = '0;
                    load   = 1'b1;
                end
            end else begin
                nstate = S_ISSUE;
                nslot  = slot + 1'b1;
                nrep   = '0;
                load   = 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            slot     <= '0;
            rep_cnt  <= '0;
            loop_cnt <= '0;
            dly_cnt  <= '0;
        end else begin
            state    <= nstate;
            slot     <= nslot;
            rep_cnt  <= nrep;
            loop_cnt <= nloop;
            dly_cnt  <= ndly;
        end
    end

    // outputs
    always_comb begin
        busy     = (state != S_IDLE);
        issue    = (state == S_ISSUE);
        nxt_slot = nslot;
    end
endmodule

// File: rtl/dcs_addr_step.sv
module dcs_addr_step
    import dcs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [ADDR_W-1:0]  ld_addr,
    input  logic [BANK_W-1:0]  ld_bank,
    input  logic               step_bank,
    input  logic               step_addr,
    input  logic [WRAP_W-1:0]  wrap,
    output logic [ADDR_W-1:0]  cur_addr,
    output logic [BANK_W-1:0]  cur_bank
);
    localparam logic [WRAP_W-1:0] WRAP_FULL = WRAP_W'(ADDR_W);

    logic [ADDR_W-1:0] mask;

    always_comb begin
        if (wrap == '0 || wrap >= WRAP_FULL)
            mask = '1;
        else
            mask = (ADDR_W'(1) << wrap) - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cur_bank <= '0;
        end else if (load) begin
            cur_addr <= ld_addr;
            cur_bank <= ld_bank;
        end else if (step) begin
            if (step_bank) cur_bank <= cur_bank + 1'b1;
            if (step_addr) cur_addr <= (cur_addr + 1'b1) & mask;
        end
    end
endmodule

// File: rtl/dcs_cmd_seq.sv
module dcs_cmd_seq
    import dcs_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_we,
    input  logic [4:0]   reg_addr,
    input  logic [31:0]  reg_wdata,
    output logic [31:0]  reg_rdata,
    output logic         cmd_valid,
    output logic [2:0]   cmd_code,
    output logic [3:0]   cmd_cs,
    output logic [2:0]   cmd_bank,
    output logic [17:0]  cmd_addr,
    output logic [1:0]   cmd_dir,
    output logic         busy
);
    slot_cfg_t           cfg [NSLOT];
    slot_cfg_t           cur, nxt;
    logic                start_w, timer_w, done_n_w, done_t_w, run_end_w;
    logic [LOOP_W-1:0]   loops_w;
    logic [SLOT_W-1:0]   last_w, slot_w, nslot_w;
    logic                load_w, step_w, issue_w;
    logic [ADDR_W-1:0]   addr_w;
    logic [BANK_W-1:0]   bank_w;
    logic [NWORD*32-1:0] slot_flat_w;

    dcs_regfile u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .busy      (busy),
        .run_end   (run_end_w),
        .rdata     (reg_rdata),
        .start     (start_w),
        .cfg       (cfg),
        .loops     (loops_w),
        .last_slot (last_w),
        .timer     (timer_w),
        .done_n    (done_n_w),
        .done_t    (done_t_w),
        .slot_flat (slot_flat_w)
    );

    assign cur = cfg[slot_w];
    assign nxt = cfg[nslot_w];

    dcs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_w),
        .loops     (loops_w),
        .last_slot (last_w),
        .reps      (cur.reps),
        .gap       (cur.gap),
        .hold      (cur.hold),
        .slot      (slot_w),
        .nxt_slot  (nslot_w),
        .load      (load_w),
        .step      (step_w),
        .issue     (issue_w),
        .busy      (busy),
        .run_end   (run_end_w)
    );

    dcs_addr_step u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_w),
        .step      (step_w),
        .ld_addr   (nxt.addr),
        .ld_bank   (nxt.bank),
        .step_bank (cur.step_bank),
        .step_addr (cur.step_addr),
        .wrap      (cur.wrap),
        .cur_addr  (addr_w),
        .cur_bank  (bank_w)
    );

    always_comb begin
        cmd_valid = issue_w && !timer_w;
        cmd_code  = CMD_NOP;
        cmd_cs    = '0;
        cmd_bank  = '0;
        cmd_addr  = '0;
        cmd_dir   = DIR_NONE;
        if (cmd_valid) begin
            cmd_code = cur.code;
            cmd_cs   = CS_W'(1) << cur.rank;
            cmd_bank = bank_w;
            cmd_addr = addr_w;
            cmd_dir  = cur.dir;
        end
    end
endmodule

// File: rtl/dcs_chk.sv
module dcs_chk
    import dcs_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 busy,
    input logic                 start,
    input logic                 timer,
    input logic                 done_n,
    input logic                 done_t,
    input logic                 cmd_valid,
    input logic [3:0]           cmd_cs,
    input logic [1:0]           cmd_dir,
    input logic [NWORD*32-1:0]  slot_flat
);
    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !done_n && !done_t));

    // R9
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($countones(cmd_cs) == 1));

    // R9
    cs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> (cmd_cs == '0));

    // R8
    dir_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_dir != 2'd3));

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_n || done_t) |-> !busy);

    // R11
    timer_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && timer) |-> !cmd_valid);

    // R12
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(slot_flat));
endmodule

bind dcs_cmd_seq dcs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .start     (start_w),
    .timer     (timer_w),
    .done_n    (done_n_w),
    .done_t    (done_t_w),
    .cmd_valid (cmd_valid),
    .cmd_cs    (cmd_cs),
    .cmd_dir   (cmd_dir),
    .slot_flat (slot_flat_w)
);

// File: tb/dcs_cmd_seq_tb.sv
`timescale 1ns/1ps
module dcs_cmd_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmd_valid;
    logic [2:0]  cmd_code;
    logic [3:0]  cmd_cs;
    logic [2:0]  cmd_bank;
    logic [17:0] cmd_addr;
    logic [1:0]  cmd_dir;
    logic        busy;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    // bench copy of slot settings
    int b_code[4], b_rank[4], b_reps[4], b_gap[4], b_wait[4], b_dir[4];
    int b_addr[4], b_bank[4], b_sb[4], b_sa[4], b_wrap[4];
    logic [31:0] b_w0[4];

    // expected schedule
    int          e_n;
    int          e_end;
    int          e_t[256];
    logic [29:0] e_val[256];

    always #2.5 clk = ~clk;

    dcs_cmd_seq u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_cs(cmd_cs), .cmd_bank(cmd_bank),
        .cmd_addr(cmd_addr), .cmd_dir(cmd_dir), .busy(busy)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired act=%0d exp=<100000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_slot(input int s, input int code, input int rank, input int reps,
                            input int gap, input int wt, input int dir, input int addr,
                            input int bank, input int sb, input int sa, input int wrap);
        logic [31:0] w0, w1, w2, w3;
        b_code[s] = code; b_rank[s] = rank; b_reps[s] = reps; b_gap[s] = gap;
        b_wait[s] = wt; b_dir[s] = dir; b_addr[s] = addr; b_bank[s] = bank;
        b_sb[s] = sb; b_sa[s] = sa; b_wrap[s] = wrap;
        w0 = 32'(code) | (32'(rank) << 4);
        w1 = 32'(reps) | (32'(gap) << 10) | (32'(wt) << 18) | (32'(dir) << 26);
        w2 = 32'(addr) | (32'(bank) << 18);
        w3 = 32'(sb) | (32'(sa) << 1) | (32'(wrap) << 2);
        b_w0[s] = w0;
        wr(5'(4*s), w0); wr(5'(4*s+1), w1); wr(5'(4*s+2), w2); wr(5'(4*s+3), w3);
    endtask

    // reference schedule from the requirements
    task automatic model(input int last, input int loops, input bit timer);
        int t, nl;
        t = 0; e_n = 0;
        nl = (loops == 0) ? 1 : loops;
        for (int lp = 0; lp < nl; lp++) begin
            for (int s = 0; s <= last; s++) begin
                int r, a, b;
                r = (b_reps[s] == 0) ? 1 : b_reps[s];
                a = b_addr[s]; b = b_bank[s];
                for (int k = 0; k < r; k++) begin
                    if (!timer) begin
                        e_t[e_n] = t;
                        e_val[e_n] = {3'(b_code[s]), 4'(1 << b_rank[s]), 3'(b), 18'(a), 2'(b_dir[s])};
                        e_n++;
                    end
                    if (k < r - 1) begin
                        if (b_sb[s] != 0) b = (b + 1) % 8;
                        if (b_sa[s] != 0) begin
                            a = a + 1;
                            if (b_wrap[s] != 0 && b_wrap[s] < 18) a = a % (1 << b_wrap[s]);
                            else a = a % (1 << 18);
                        end
                        t = t + b_gap[s] + 1;
                    end else begin
                        t = t + b_wait[s] + 1;
                    end
                end
            end
        end
        e_end = t;
    endtask

    // start a run and compare every cycle with the model
    task automatic run(input string name, input int last, input int loops, input bit timer,
                       input bit inject);
        int idx;
        logic [31:0] st;
        logic [29:0] act;
        model(last, loops, timer);
        idx = 0;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 5'd16;
        reg_wdata = 32'(loops) | (32'(last) << 18) | (32'(timer) << 22);
        @(negedge clk);
        reg_we = 1'b0;
        for (int t = 0; t <= e_end; t++) begin
            if (t == 0) begin
                rd(5'd17, st);
                chk(st[6:0] == 7'h01, {name, " R2 start sets busy, clears done"}, st, 32'h1);
            end
            act = {cmd_code, cmd_cs, cmd_bank, cmd_addr, cmd_dir};
            if (cmd_valid) begin
                if (idx < e_n && e_t[idx] == t) begin
                    chk(act == e_val[idx], {name, " R3 R4 R5 R6 R7 R8 R9 command fields"}, act, e_val[idx]);
                    idx++;
                end else begin
                    chk(1'b0, {name, " R3 R4 R5 R6 R11 unexpected command"}, 64'(t), 64'(idx < e_n ? e_t[idx] : -1));
                end
            end else if (idx < e_n && e_t[idx] == t) begin
                chk(1'b0, {name, " R3 R4 R5 R6 missing command"}, 64'(t), 64'(e_t[idx]));
                idx++;
            end
            if (t == e_end - 1)
                chk(busy == 1'b1, {name, " R10 busy before end"}, busy, 1);
            if (t == e_end) begin
                rd(5'd17, st);
                chk(busy == 1'b0, {name, " R10 busy clears"}, busy, 0);
                if (timer)
                    chk(st[6:0] == 7'h40, {name, " R11 timer done bit"}, st, 32'h40);
                else
                    chk(st[6:0] == 7'h10, {name, " R10 done bit"}, st, 32'h10);
            end
            if (inject && t == 2) begin
                reg_we = 1'b1; reg_addr = 5'd0; reg_wdata = 32'h5;
            end else if (inject && t == 3) begin
                reg_we = 1'b1; reg_addr = 5'd16; reg_wdata = 32'h1;
            end else begin
                reg_we = 1'b0;
            end
            if (t < e_end) @(negedge clk);
        end
        reg_we = 1'b0;
        chk(idx == e_n, {name, " R3 R6 command count"}, idx, e_n);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        @(negedge clk);
        chk(busy == 1'b0 && cmd_valid == 1'b0, "R1 reset outputs idle", {busy, cmd_valid}, 0);
        rd(5'd17, d);
        chk(d == 32'h0, "R1 reset status", d, 0);
        rd(5'd16, d);
        chk(d == 32'h0, "R1 reset run control", d, 0);
    endtask

    task automatic t_single();
        set_slot(0, 1, 1, 1, 0, 0, 0, 'h123, 2, 0, 0, 0);
        run("single", 0, 1, 1'b0, 1'b0);
    endtask

    task automatic t_mixed();
        set_slot(0, 2, 0, 3, 2, 4, 0, 'h10, 0, 0, 0, 0);
        set_slot(1, 3, 2, 0, 5, 0, 0, 'h3ff, 1, 0, 0, 0);
        set_slot(2, 6, 3, 5, 0, 1, 2, 6, 6, 1, 1, 3);
        set_slot(3, 7, 1, 2, 1, 3, 1, 'h20000, 7, 0, 1, 0);
        run("mixed", 3, 2, 1'b0, 1'b0);
    endtask

    task automatic t_long();
        set_slot(0, 5, 2, 32, 0, 2, 1, 'h3fff0, 3, 0, 1, 18);
        set_slot(1, 4, 0, 1, 0, 7, 0, 0, 0, 0, 0, 0);
        run("long_loops0", 1, 0, 1'b0, 1'b0);
    endtask

    task automatic t_step_once();
        set_slot(0, 5, 3, 1, 0, 1, 1, 5, 4, 1, 1, 2);
        run("reps1_nostep_R7", 0, 3, 1'b0, 1'b0);
    endtask

    task automatic t_timer();
        set_slot(0, 2, 0, 3, 2, 4, 0, 'h10, 0, 0, 0, 0);
        set_slot(1, 0, 1, 2, 0, 3, 2, 'h44, 1, 0, 0, 0);
        run("timer_R11", 1, 2, 1'b1, 1'b0);
    endtask

    task automatic t_busy_writes();
        logic [31:0] d;
        set_slot(0, 6, 1, 6, 1, 2, 2, 'h100, 1, 0, 1, 0);
        run("busy_writes_R12", 0, 1, 1'b0, 1'b1);
        rd(5'd0, d);
        chk(d == b_w0[0], "R12 slot word kept while busy", d, b_w0[0]);
        rd(5'd16, d);
        chk(d == 32'h1, "R12 run control kept while busy", d, 32'h1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(busy == 1'b0 && cmd_valid == 1'b0, "R12 no restart from busy write", {busy, cmd_valid}, 0);
        end
        rd(5'd17, d);
        chk(d[6:0] == 7'h10, "R10 status kept after reads", d, 32'h10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_mixed();
        t_long();
        t_step_once();
        t_timer();
        t_busy_writes();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule